// File: doc/BRIEF.md
# SMBus Byte-Access Memory Target

This block is an SMBus target that answers on a single 7-bit bus address and serves 256 bytes. The 8-bit command code of each transaction is used directly as the byte address. Command bit 7 picks one of two halves. With bit 7 at 0 the access goes to a protected information region, which is filled only through a preload port. With bit 7 at 1 it goes to a writable scratch region.

Only two transactions are served. In Write Byte the host sends the address, the command and a data byte. In Read Byte the host sends the address and the command, then a repeated Start, the address with the read bit, and clocks one data byte back before it NACKs.

A write to the information half is acknowledged on every byte, but the data is dropped. A write to the scratch half stores the byte. It also starts a hold-off period, counted in clock cycles, during which the target refuses its own address for both halves.

SCL and SDA come in through a synchronizer and are sampled on the system clock. SDA is driven as an open-drain line: `sdaOut` is held at 0 and `sdaOe` pulls the line low.

Top module: `smbus_byte_target`

## Requirements
- R1: After reset `sdaOe` is 0 and every scratch byte reads back as 8'h00.
- R2: The first byte after a Start carries the 7-bit address MSB first and then the direction bit (0 = write, 1 = read). The target pulls SDA low in the ninth clock only when the address equals `TARGET_ADDR`. On a mismatch it does not pull SDA low and stays silent until the next Start or Stop.
- R3: In a Write Byte whose command has bit 7 = 1, the target acknowledges the command and the data byte. It stores the data at index command[6:0] of the scratch half and leaves every other byte unchanged.
- R4: In a Read Byte the target returns the byte addressed by the command, MSB first. SDA changes only while SCL is low, and SDA is released in the ninth clock of the returned byte.
- R5: A command with bit 7 = 0 reads the information half at index command[6:0]. That half is written only through the preload port: `romLoadEn` high for one clock stores `romLoadData` at `romLoadAddr`.
- R6: A Write Byte whose command has bit 7 = 0 is acknowledged on all three bytes. The information byte stays unchanged, and no hold-off period starts.
- R7: Each stored scratch write starts a hold-off of `BUSY_CYCLES` clock cycles. During it the target does not acknowledge its own address, for either half. After it ends, transactions are acknowledged again.
- R8: An address byte with the read bit set is acknowledged only if a command byte has been received since the last Stop.
- R9: A Stop at any point returns the target to idle without storing anything. A Start at any point restarts address reception.
- R10: While idle the target leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOut | output | 1 | SDA output value, always 0 (open drain) |
| sdaOe | output | 1 | High to pull SDA low |
| romLoadEn | input | 1 | Preload strobe for the information half |
| romLoadAddr | input | 7 | Preload byte index |
| romLoadData | input | 8 | Preload byte value |

## Verification
A bit counter or a state that is out of step with the host shows up at the ninth clock of the affected byte. There the acknowledge is missing, or it lands one bit early or late and corrupts the next byte's sampled value, which is visible within one byte time.

A wrong pointer or a wrong region decision shows up only on a later Read Byte, as a wrong data value. For that reason every write is followed by a read-back.

A hold-off counter that runs too short or too long shows up as an address acknowledge where none should be, or a missing one, within one transaction after the write. An unprotected information half shows up on the read that immediately follows a write to it.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int CMD_W  = 8;
  localparam int HALF_N = 2 ** (CMD_W - 1);
  localparam int IDX_W  = CMD_W - 1;

  typedef enum logic [3:0] {
    StIdle,
    StAddr,
    StAckAddr,
    StCmd,
    StAckCmd,
    StWrData,
    StAckData,
    StRdData,
    StRdAck,
    StSkip
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic commitWr;
    logic loadTx;
    logic shiftTx;
  } ctrlStrobe_t;
endpackage

// File: rtl/sbt_pin_sync.sv
module sbt_pin_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= (chain << 1) | STAGES'(rawIn[i]);
    end
    assign syncOut[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
  import sbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclS,
  input  logic        sdaS,
  input  logic        addrHit,
  input  logic        rwBit,
  input  logic        busy,
  input  logic        txMsb,
  output ctrlStrobe_t strobe,
  output logic        sdaOe,
  output busState_t   busState
);
  logic      sclPrev, sdaPrev;
  logic      sclRise, sclFall, startDet, stopDet;
  logic [2:0] bitCnt;
  logic      driveLow, cmdSeen, readDir;
  logic      lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign lastBit  = (bitCnt == 3'd7);

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclRise && (busState == StAddr || busState == StCmd || busState == StWrData);
    strobe.loadPtr  = sclRise && busState == StCmd && lastBit;
    strobe.commitWr = sclRise && busState == StWrData && lastBit;
    strobe.loadTx   = sclFall && busState == StAckAddr && driveLow && readDir;
    strobe.shiftTx  = sclFall && busState == StRdData && !lastBit;
  end

  assign sdaOe = driveLow | ((busState == StRdData) & ~txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState <= StIdle;
      bitCnt   <= '0;
      driveLow <= 1'b0;
      cmdSeen  <= 1'b0;
      readDir  <= 1'b0;
    end else if (stopDet) begin
      busState <= StIdle;
      bitCnt   <= '0;
      driveLow <= 1'b0;
      cmdSeen  <= 1'b0;
    end else if (startDet) begin
      busState <= StAddr;
      bitCnt   <= '0;
      driveLow <= 1'b0;
    end else begin
      case (busState)
        StAddr: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (lastBit) begin
            readDir  <= rwBit;
            busState <= (addrHit && !busy && (!rwBit || cmdSeen)) ? StAckAddr : StSkip;
          end
        end
        StCmd: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (lastBit) begin
            cmdSeen  <= 1'b1;
            busState <= StAckCmd;
          end
        end
        StWrData: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (lastBit) busState <= StAckData;
        end
        StAckAddr, StAckCmd, StAckData: if (sclFall) begin
          if (!driveLow) begin
            driveLow <= 1'b1;
          end else begin
            driveLow <= 1'b0;
            bitCnt   <= '0;
            case (busState)
              StAckAddr: busState <= readDir ? StRdData : StCmd;
              StAckCmd:  busState <= StWrData;
              default:   busState <= StSkip;
            endcase
          end
        end
        StRdData: if (sclFall) begin
          if (lastBit) busState <= StRdAck;
          else         bitCnt   <= bitCnt + 3'd1;
        end
        StRdAck: if (sclRise) busState <= StSkip;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbt_data.sv
module sbt_data
  import sbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h50,
  parameter int         BUSY_CYCLES = 2_500_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaS,
  input  ctrlStrobe_t      strobe,
  input  logic             romLoadEn,
  input  logic [IDX_W-1:0] romLoadAddr,
  input  logic [7:0]       romLoadData,
  output logic             addrHit,
  output logic             rwBit,
  output logic             busy,
  output logic             txMsb,
  output logic             ptrMsb
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]       rxReg, txReg, nextByte;
  logic [CMD_W-1:0] ptr;
  logic [BUSY_W-1:0] busyCnt;
  logic [7:0]       infoMem    [HALF_N];
  logic [7:0]       scratchMem [HALF_N];
  logic             scratchWe;
  logic [7:0]       rdByte;

  assign nextByte  = {rxReg[6:0], sdaS};
  assign addrHit   = (nextByte[7:1] == TARGET_ADDR);
  assign rwBit     = nextByte[0];
  assign scratchWe = strobe.commitWr & ptr[CMD_W-1];
  assign rdByte    = ptr[CMD_W-1] ? scratchMem[ptr[IDX_W-1:0]] : infoMem[ptr[IDX_W-1:0]];
  assign busy      = (busyCnt != '0);
  assign txMsb     = txReg[7];
  assign ptrMsb    = ptr[CMD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '1;
      ptr   <= '0;
    end else begin
      if (strobe.shiftIn) rxReg <= nextByte;
      if (strobe.loadPtr) ptr   <= nextByte;
      if (strobe.loadTx)       txReg <= rdByte;
      else if (strobe.shiftTx) txReg <= {txReg[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (scratchWe) busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy) busyCnt <= busyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_N; i++) scratchMem[i] <= '0;
    end else if (scratchWe) begin
      scratchMem[ptr[IDX_W-1:0]] <= nextByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_N; i++) infoMem[i] <= '0;
    end else if (romLoadEn) begin
      infoMem[romLoadAddr] <= romLoadData;
    end
  end
endmodule

// File: rtl/smbus_byte_target.sv
module smbus_byte_target
  import sbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h50,
  parameter int         BUSY_CYCLES = 2_500_000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOut,
  output logic       sdaOe,
  input  logic       romLoadEn,
  input  logic [6:0] romLoadAddr,
  input  logic [7:0] romLoadData
);
  logic        sclS, sdaS;
  logic        addrHit, rwBit, busy, txMsb, ptrMsb;
  ctrlStrobe_t strobe;
  busState_t   busState;

  assign sdaOut = 1'b0;

  sbt_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk(clk), .rstN(rstN), .rawIn({sclIn, sdaIn}), .syncOut({sclS, sdaS})
  );

  sbt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .addrHit(addrHit), .rwBit(rwBit), .busy(busy), .txMsb(txMsb),
    .strobe(strobe), .sdaOe(sdaOe), .busState(busState)
  );

  sbt_data #(.TARGET_ADDR(TARGET_ADDR), .BUSY_CYCLES(BUSY_CYCLES)) i_data (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strobe(strobe),
    .romLoadEn(romLoadEn), .romLoadAddr(romLoadAddr), .romLoadData(romLoadData),
    .addrHit(addrHit), .rwBit(rwBit), .busy(busy), .txMsb(txMsb), .ptrMsb(ptrMsb)
  );
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
  import sbt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclS,
  input logic        sdaS,
  input logic        sdaOe,
  input logic        busy,
  input logic        ptrMsb,
  input busState_t   busState,
  input ctrlStrobe_t strobe
);
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busState == StIdle |-> !sdaOe);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWr && ptrMsb |=> busy);

  // R6
  info_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWr && !ptrMsb && !busy |=> !busy);

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busState == StAckAddr |-> !busy);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclS && $past(sclS) && !$past(sdaS) && sdaS |=> busState == StIdle);

  // R4
  data_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe != $past(sdaOe) |-> !sclS);
endmodule

bind smbus_byte_target sbt_checker i_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .sdaOe(sdaOe),
  .busy(busy), .ptrMsb(ptrMsb), .busState(busState), .strobe(strobe)
);

// File: tb/test_smbus_byte_target.sv
`timescale 1ns/1ps
module test_smbus_byte_target;
  localparam logic [6:0] DEV  = 7'h50;
  localparam int         BUSY = 3000;
  localparam int         Q    = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, scl, sdaHost, romLoadEn;
  logic [6:0] romLoadAddr;
  logic [7:0] romLoadData;
  wire sdaOut, sdaOe;
  wire sdaLine = sdaHost & ~(sdaOe & ~sdaOut);

  int nTests = 0;
  int nFail  = 0;

  smbus_byte_target #(.TARGET_ADDR(DEV), .BUSY_CYCLES(BUSY)) i_smbus_byte_target (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOut(sdaOut), .sdaOe(sdaOe),
    .romLoadEn(romLoadEn), .romLoadAddr(romLoadAddr), .romLoadData(romLoadData)
  );

  function automatic logic [7:0] infoVal(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart;
    sdaHost = 1'b1; waitQ;
    scl = 1'b1;     waitQ;
    sdaHost = 1'b0; waitQ;
    scl = 1'b0;     waitQ;
  endtask

  task automatic busStop;
    sdaHost = 1'b0; waitQ;
    scl = 1'b1;     waitQ;
    sdaHost = 1'b1; waitQ;
  endtask

  task automatic putBit(input logic b);
    sdaHost = b; waitQ;
    scl = 1'b1;  waitQ; waitQ;
    scl = 1'b0;  waitQ;
  endtask

  task automatic getBit(output logic b);
    sdaHost = 1'b1; waitQ;
    scl = 1'b1;     waitQ;
    b = sdaLine;    waitQ;
    scl = 1'b0;     waitQ;
  endtask

  task automatic putByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic getByteNack(output logic [7:0] d, output logic released);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    getBit(b);
    released = b;
  endtask

  task automatic doWrite(input logic [6:0] dev, input logic [7:0] cmd, input logic [7:0] data,
                         output logic a0, output logic a1, output logic a2);
    busStart;
    putByte({dev, 1'b0}, a0);
    putByte(cmd, a1);
    putByte(data, a2);
    busStop;
  endtask

  task automatic doRead(input logic [7:0] cmd, output logic a0, output logic a1,
                        output logic a2, output logic [7:0] d, output logic rel);
    busStart;
    putByte({DEV, 1'b0}, a0);
    putByte(cmd, a1);
    busStart;
    putByte({DEV, 1'b1}, a2);
    getByteNack(d, rel);
    busStop;
  endtask

  task automatic tReset;
    chk("R1 sdaOe after reset", {7'd0, sdaOe}, 8'd0);
    chk("R10 line idle", {7'd0, sdaLine}, 8'd1);
  endtask

  task automatic tPreload;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      romLoadEn = 1'b1; romLoadAddr = 7'(a); romLoadData = infoVal(a);
    end
    @(negedge clk);
    romLoadEn = 1'b0;
  endtask

  task automatic tInfoRead;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    int idx [3] = '{0, 5, 127};
    foreach (idx[k]) begin
      doRead(8'(idx[k]), a0, a1, a2, d, rel);
      chk("R2 address ack", {5'd0, a0, a1, a2}, 8'h07);
      chk("R5 info read", d, infoVal(idx[k]));
      chk("R4 release in ninth clock", {7'd0, rel}, 8'd1);
    end
  endtask

  task automatic tScratchReset;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    doRead(8'h80, a0, a1, a2, d, rel);
    chk("R1 scratch 80 reset", d, 8'h00);
    doRead(8'hFF, a0, a1, a2, d, rel);
    chk("R1 scratch FF reset", d, 8'h00);
  endtask

  task automatic tScratchWrite;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    doWrite(DEV, 8'h83, 8'hA5, a0, a1, a2);
    chk("R3 write acks", {5'd0, a0, a1, a2}, 8'h07);
    doRead(8'h00, a0, a1, a2, d, rel);
    chk("R7 busy info nack", {7'd0, a0}, 8'd0);
    doRead(8'h83, a0, a1, a2, d, rel);
    chk("R7 busy scratch nack", {7'd0, a0}, 8'd0);
    repeat (BUSY + 200) @(negedge clk);
    doRead(8'h83, a0, a1, a2, d, rel);
    chk("R7 ack after hold-off", {5'd0, a0, a1, a2}, 8'h07);
    chk("R3 read back 83", d, 8'hA5);
    doWrite(DEV, 8'hFF, 8'h3C, a0, a1, a2);
    repeat (BUSY + 200) @(negedge clk);
    doRead(8'hFF, a0, a1, a2, d, rel);
    chk("R3 read back FF", d, 8'h3C);
    doRead(8'hFE, a0, a1, a2, d, rel);
    chk("R3 neighbour FE unchanged", d, 8'h00);
  endtask

  task automatic tInfoWrite;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    doWrite(DEV, 8'h05, ~infoVal(5), a0, a1, a2);
    chk("R6 protected write acks", {5'd0, a0, a1, a2}, 8'h07);
    doRead(8'h05, a0, a1, a2, d, rel);
    chk("R6 no hold-off", {7'd0, a0}, 8'd1);
    chk("R6 info unchanged", d, infoVal(5));
  endtask

  task automatic tWrongAddr;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    doWrite(7'h51, 8'h90, 8'h77, a0, a1, a2);
    chk("R2 foreign address nack", {5'd0, a0, a1, a2}, 8'h00);
    doRead(8'h90, a0, a1, a2, d, rel);
    chk("R2 foreign write ignored ack", {7'd0, a0}, 8'd1);
    chk("R2 foreign write ignored data", d, 8'h00);
  endtask

  task automatic tReadNoCmd;
    logic a;
    busStart;
    putByte({DEV, 1'b1}, a);
    busStop;
    chk("R8 read without command nack", {7'd0, a}, 8'd0);
  endtask

  task automatic tAbort;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    busStart;
    putByte({DEV, 1'b0}, a0);
    putByte(8'h91, a1);
    busStop;
    doRead(8'h91, a0, a1, a2, d, rel);
    chk("R9 stop before data no hold-off", {7'd0, a0}, 8'd1);
    chk("R9 stop before data no store", d, 8'h00);
    busStart;
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b0);
    busStop;
    doRead(8'h05, a0, a1, a2, d, rel);
    chk("R9 stop inside address", d, infoVal(5));
  endtask

  task automatic tRestart;
    logic a0, a1, a2, rel;
    logic [7:0] d;
    busStart;
    putByte({DEV, 1'b0}, a0);
    putByte(8'h92, a1);
    putBit(1'b1); putBit(1'b1); putBit(1'b1);
    busStart;
    putByte({DEV, 1'b0}, a0);
    putByte(8'h93, a1);
    putByte(8'h44, a2);
    busStop;
    chk("R9 restart acks", {5'd0, a0, a1, a2}, 8'h07);
    repeat (BUSY + 200) @(negedge clk);
    doRead(8'h92, a0, a1, a2, d, rel);
    chk("R9 cut byte not stored", d, 8'h00);
    doRead(8'h93, a0, a1, a2, d, rel);
    chk("R9 restarted write stored", d, 8'h44);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; scl = 1'b1; sdaHost = 1'b1;
    romLoadEn = 1'b0; romLoadAddr = '0; romLoadData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset;
    tPreload;
    tInfoRead;
    tScratchReset;
    tScratchWrite;
    tInfoWrite;
    tWrongAddr;
    tReadNoCmd;
    tAbort;
    tRestart;
    tReset;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule